// File: doc/BRIEF.md
# Half-Precision to Signed Integer Converter

This unit turns one 16-bit IEEE half-precision value into a signed two's-complement integer that is either 32 or 64 bits wide. The inputs are sampled on a rising clock edge and the integer result and its two status flags appear one cycle later.

The rounding mode has two possible sources. A global 2-bit field is the default. A per-operation field replaces it only when its enable is set and the operand came from a register. The result is wide only when the 64-bit execution mode is active and the wide select is asserted. A narrow result sits in the low 32 bits of the output and the upper 32 bits are zero.

Infinities and NaNs cannot be represented as integers. For these inputs the unit returns the integer-indefinite pattern and raises both the invalid flag and the inexact flag. Any finite operand that is not a whole number raises only the inexact flag.

Top module: `fp16_sint_cvt`

## Requirements
- R1: The result and both flags are registered, so they reflect the inputs sampled at the previous rising edge. While rst_n is low, all outputs are 0.
- R2: The operand uses 1 sign bit (bit 15), a 5-bit exponent with bias 15 (bits 14:10) and a 10-bit fraction (bits 9:0). A finite input with an integral value converts exactly and raises no flag. This covers the extremes ±65504.
- R3: The result is 64 bits wide only when mode64=1 and wide_sel=1. In every other case, result[31:0] holds the 32-bit two's-complement value and result[63:32] is 0.
- R4: When mode64=0, wide_sel has no effect on the result.
- R5: The rounding mode is rm_op when both op_rm_en=1 and src_in_reg=1. Otherwise the rounding mode is rm_global.
- R6: The rounding encodings are 00 = nearest with ties to even, 01 = toward negative infinity, 10 = toward positive infinity, and 11 = toward zero. A non-integral finite input raises inexact.
- R7: An input with exponent 31 (infinity or NaN) raises both invalid and inexact. It returns 0x0000_0000_8000_0000 when the result is narrow and 0x8000_0000_0000_0000 when it is wide. No finite input raises invalid.
- R8: A subnormal nonzero input produces 0, or produces ±1 under the directed modes that round away from zero. It always raises inexact.
- R9: A negative finite input yields the two's-complement negation of its rounded magnitude. Negative zero yields 0 with no flag raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 16 | Half-precision operand |
| rm_global | input | 2 | Global rounding mode |
| rm_op | input | 2 | Per-operation rounding mode |
| op_rm_en | input | 1 | Enable for the per-operation rounding mode |
| src_in_reg | input | 1 | The operand came from a register |
| mode64 | input | 1 | 64-bit execution mode is active |
| wide_sel | input | 1 | Request for a 64-bit result |
| result | output | 64 | Signed integer result |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Precision flag |

## Verification
Rounding and negation can both act on the same operand in one cycle. A negative value with a fractional part first has its magnitude rounded and then has its sign applied, so the direction of each directed mode matters. The bench provokes this with -2.5 under all four modes, in both result widths, and with the override selecting the mode, and it compares each result against a hand-computed two's-complement value. A second pairing is the override source combined with the wide path. For that case, -2.5 is driven under an override toward negative infinity while the global field says toward zero, and the bench expects the wide value -3.

// File: rtl/fp16_sint_cvt.sv
module fp16_sint_cvt #(
  parameter int FRAC_W = 24,
  parameter int FX_W   = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] src,
  input  logic [1:0]  rm_global,
  input  logic [1:0]  rm_op,
  input  logic        op_rm_en,
  input  logic        src_in_reg,
  input  logic        mode64,
  input  logic        wide_sel,
  output logic [63:0] result,
  output logic        invalid,
  output logic        inexact
);
  localparam int INT_W = FX_W - FRAC_W;

  logic              sgn;
  logic [4:0]        expo;
  logic [9:0]        man;
  logic              special;
  logic [FX_W-1:0]   fx;
  logic [INT_W-1:0]  whole;
  logic [FRAC_W-1:0] rest;
  logic              lost, half, tail, bump, wide;
  logic [1:0]        rm;
  logic [INT_W:0]    mag;
  logic [63:0]       sval, nxt;
  logic              wide_q, started;

  assign sgn     = src[15];
  assign expo    = src[14:10];
  assign man     = src[9:0];
  assign special = &expo;
  assign wide    = mode64 & wide_sel;
  assign rm      = (op_rm_en && src_in_reg) ? rm_op : rm_global;

  assign fx = (expo == 5'd0) ? FX_W'(man)
                             : (FX_W'({1'b1, man}) << (expo - 5'd1));

  assign whole = fx[FX_W-1:FRAC_W];
  assign rest  = fx[FRAC_W-1:0];
  assign lost  = |rest;
  assign half  = rest[FRAC_W-1];
  assign tail  = |rest[FRAC_W-2:0];

  always_comb begin
    case (rm)
      2'b00:   bump = half & (tail | whole[0]);
      2'b01:   bump = lost & sgn;
      2'b10:   bump = lost & ~sgn;
      default: bump = 1'b0;
    endcase
  end

  assign mag  = {1'b0, whole} + (INT_W+1)'(bump);
  assign sval = sgn ? -(64'(mag)) : 64'(mag);

  always_comb begin
    if (special)   nxt = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    else if (wide) nxt = sval;
    else           nxt = {32'h0, sval[31:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      invalid <= 1'b0;
      inexact <= 1'b0;
      wide_q  <= 1'b0;
      started <= 1'b0;
    end else begin
      result  <= nxt;
      invalid <= special;
      inexact <= special | lost;
      wide_q  <= wide;
      started <= 1'b1;
    end
  end

  AST_INDEF_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> result == (wide_q ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000)); // R7
  AST_INVALID_SETS_PRECISION: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> inexact); // R7
  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> result[63:32] == 32'h0); // R3
  AST_INVALID_ONLY_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> invalid == (&$past(src[14:10]))); // R7
  AST_NEG_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(src[14:0]) == 15'h0) |-> (result == 64'h0 && !invalid && !inexact)); // R9
  AST_WIDE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !$past(mode64)) |-> result[63:32] == 32'h0); // R4
endmodule

// File: tb/fp16_sint_cvt_tb.sv
module fp16_sint_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [1:0]  rm_global = '0, rm_op = '0;
  logic        op_rm_en = 1'b0, src_in_reg = 1'b0, mode64 = 1'b0, wide_sel = 1'b0;
  logic [63:0] result;
  logic        invalid, inexact;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  fp16_sint_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .src(src), .rm_global(rm_global), .rm_op(rm_op),
    .op_rm_en(op_rm_en), .src_in_reg(src_in_reg), .mode64(mode64), .wide_sel(wide_sel),
    .result(result), .invalid(invalid), .inexact(inexact)
  );

  function automatic logic [97:0] mk(input int r, input logic [15:0] s, input logic [1:0] g,
      input logic [1:0] o, input logic oe, input logic ir, input logic lm, input logic ws,
      input logic [63:0] e, input logic iv, input logic ix);
    return {8'(r), s, g, o, oe, ir, lm, ws, e, iv, ix};
  endfunction

  localparam int NV = 34;
  localparam logic [97:0] VEC [NV] = '{
    mk(2, 16'h3C00, 2'd0, 2'd0, 0, 0, 0, 0, 64'h1, 0, 0),                    // R2 1.0
    mk(2, 16'h4200, 2'd0, 2'd0, 0, 0, 0, 0, 64'h3, 0, 0),                    // R2 3.0
    mk(2, 16'h6400, 2'd0, 2'd0, 0, 0, 0, 0, 64'h400, 0, 0),                  // R2 1024
    mk(2, 16'h7BFF, 2'd0, 2'd0, 0, 0, 0, 0, 64'hFFE0, 0, 0),                 // R2 max
    mk(6, 16'h3E00, 2'd0, 2'd0, 0, 0, 0, 0, 64'h2, 0, 1),                    // R6 1.5 tie up
    mk(6, 16'h4100, 2'd0, 2'd0, 0, 0, 0, 0, 64'h2, 0, 1),                    // R6 2.5 tie even
    mk(6, 16'h4100, 2'd1, 2'd0, 0, 0, 0, 0, 64'h2, 0, 1),                    // R6 down
    mk(6, 16'h4100, 2'd2, 2'd0, 0, 0, 0, 0, 64'h3, 0, 1),                    // R6 up
    mk(6, 16'h4100, 2'd3, 2'd0, 0, 0, 0, 0, 64'h2, 0, 1),                    // R6 zero
    mk(6, 16'h3800, 2'd0, 2'd0, 0, 0, 0, 0, 64'h0, 0, 1),                    // R6 0.5
    mk(6, 16'h3A00, 2'd0, 2'd0, 0, 0, 0, 0, 64'h1, 0, 1),                    // R6 0.75
    mk(9, 16'hC100, 2'd0, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFE, 0, 1),            // R9 -2.5 RNE
    mk(9, 16'hC100, 2'd1, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFD, 0, 1),            // R9 -2.5 down
    mk(9, 16'hC100, 2'd2, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFE, 0, 1),            // R9 -2.5 up
    mk(9, 16'hC100, 2'd3, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFE, 0, 1),            // R9 -2.5 zero
    mk(9, 16'hBE00, 2'd0, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFE, 0, 1),            // R9 -1.5
    mk(9, 16'h8000, 2'd1, 2'd0, 0, 0, 1, 1, 64'h0, 0, 0),                    // R9 -0
    mk(3, 16'hFBFF, 2'd0, 2'd0, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_0020, 0, 0),  // R3 wide -65504
    mk(3, 16'hFBFF, 2'd0, 2'd0, 0, 0, 1, 0, 64'hFFFF_0020, 0, 0),            // R3 narrow
    mk(3, 16'hC100, 2'd1, 2'd0, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1),  // R3 wide -3
    mk(4, 16'hFBFF, 2'd0, 2'd0, 0, 0, 0, 1, 64'hFFFF_0020, 0, 0),            // R4 ignore sel
    mk(4, 16'h3C00, 2'd0, 2'd0, 0, 0, 0, 1, 64'h1, 0, 0),                    // R4 ignore sel
    mk(7, 16'h7C00, 2'd0, 2'd0, 0, 0, 0, 0, 64'h8000_0000, 1, 1),            // R7 +inf
    mk(7, 16'h7C00, 2'd0, 2'd0, 0, 0, 1, 1, 64'h8000_0000_0000_0000, 1, 1),  // R7 +inf wide
    mk(7, 16'h7E00, 2'd0, 2'd0, 0, 0, 0, 0, 64'h8000_0000, 1, 1),            // R7 NaN
    mk(7, 16'hFC00, 2'd0, 2'd0, 0, 0, 0, 1, 64'h8000_0000, 1, 1),            // R7 -inf, R4
    mk(8, 16'h0001, 2'd0, 2'd0, 0, 0, 0, 0, 64'h0, 0, 1),                    // R8 tiny RNE
    mk(8, 16'h0001, 2'd2, 2'd0, 0, 0, 0, 0, 64'h1, 0, 1),                    // R8 tiny up
    mk(8, 16'h8001, 2'd1, 2'd0, 0, 0, 0, 0, 64'hFFFF_FFFF, 0, 1),            // R8 -tiny down
    mk(8, 16'h8001, 2'd1, 2'd0, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1),  // R8 wide
    mk(8, 16'h8001, 2'd2, 2'd0, 0, 0, 0, 0, 64'h0, 0, 1),                    // R8 -tiny up
    mk(5, 16'h4100, 2'd0, 2'd2, 1, 1, 0, 0, 64'h3, 0, 1),                    // R5 override used
    mk(5, 16'h4100, 2'd0, 2'd2, 1, 0, 0, 0, 64'h2, 0, 1),                    // R5 memory source
    mk(5, 16'hC100, 2'd3, 2'd1, 1, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1)   // R5 override wide
  };

  task automatic check(input int r, input string what, input logic [63:0] gr,
      input logic gi, input logic gx, input logic [63:0] er, input logic ei, input logic ex);
    n_chk++;
    if (gr !== er || gi !== ei || gx !== ex) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
               r, what, gr, gi, gx, er, ei, ex);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R1 watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    src = 16'h7C00;
    repeat (3) @(negedge clk);
    check(1, "reset holds zero", result, invalid, inexact, 64'h0, 0, 0);   // R1
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {src, rm_global, rm_op, op_rm_en, src_in_reg, mode64, wide_sel} = VEC[i][89:66];
      @(negedge clk);
      check(int'(VEC[i][97:90]), $sformatf("vector %0d", i), result, invalid, inexact,
            VEC[i][65:2], VEC[i][1], VEC[i][0]);
    end
    // R1: one-cycle latency; new input not visible before the edge
    @(negedge clk);
    {rm_global, op_rm_en, mode64, wide_sel} = '0;
    src = 16'h3C00;
    @(negedge clk);
    src = 16'h4200;
    #5 check(1, "old value held before edge", result, invalid, inexact, 64'h1, 0, 0);
    @(negedge clk);
    check(1, "new value after edge", result, invalid, inexact, 64'h3, 0, 0);
    // R1: synchronous reset clears outputs
    src = 16'h7C00;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "reset clears flags", result, invalid, inexact, 64'h0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule